// File: doc/BRIEF.md
# Paged Edge-Detect GPIO Interrupt Unit

This block is a byte-wide, register-mapped controller for a bank of digital I/O lines arranged as 8-bit ports. Six ports are provided by default. A host writes a port's output byte to drive its lines. A line whose output bit is 0 is released, and the host can read its pin level. Every pin passes through a two-flop synchroniser before any logic uses it.

The low ports (three by default, 24 lines) can also capture edges. Each capable line has three bits: an enable bit, a polarity bit that selects rising or falling edges, and a latched event flag. These three per-port banks share one set of three addresses. A page code written to a page register chooses which bank the shared addresses reach. A latched event is acknowledged by writing the line's enable bit to 0, which clears the flag, and then writing it back to 1, which re-arms the line. A pending-summary register shows which capable ports hold an event. A level interrupt output stays high while any event is latched.

Top module: `pio_edge_irq`

## Requirements
- R1: After reset, the output drive bits, enable bits, polarity bits, latched events and page register are all 0, and the interrupt output is low.
- R2: A write to offset p (0 to 5) sets the drive bits of port p. A read of offset p returns port p's synchronised line levels. A line change made just after a clock edge is visible in this read after two further rising edges.
- R3: Offset 7 is the page register and reads back the last byte written to it. While it holds 0x80, offsets 8 to 10 reach the enable bits of ports 0 to 2. While it holds 0x40, they reach the polarity bits. While it holds 0xC0, they reach the latched events. For any other code, reads of offsets 8 to 10 return 0 and writes to them change nothing.
- R4: A polarity bit of 1 latches rising edges and a polarity bit of 0 latches falling edges. An edge in the other direction latches nothing. The event is latched on the third rising clock edge after the line changes.
- R5: A line latches an event only while its enable bit is 1. Once latched, the event holds through any later line activity until it is acknowledged.
- R6: A read of offset 6 returns in bit k a 1 exactly when port k holds at least one latched event. Bits 7:3 always read 0.
- R7: Writing an enable bit to 0 clears that line's event and leaves the events of other lines untouched. Writing the bit back to 1 re-arms the line without creating an event.
- R8: The interrupt output is high exactly when any capable port holds a latched event.
- R9: Ports 3 to 5 never latch events, and reads of offsets 11 to 15 return 0.
- R10: While the page register holds 0xC0, writes to offsets 8 to 10 leave the latched events unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 4 | Register offset within the 16-byte window |
| host_wr | input | 1 | Write strobe, sampled on the rising edge |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for host_addr (combinational) |
| line_in | input | 48 | Asynchronous pin levels |
| line_drive | output | 48 | Output drive bits, 0 = released |
| irq | output | 1 | Level interrupt |

## Verification
The bench targets paging aliasing. It writes different bytes to the enable and polarity banks at the same offset and reads each one back under its own page code. A design that decoded the page code poorly would return the wrong bank, or would accept writes under an unknown code. For acknowledge, the bench clears one of two events in a port while a third event sits in another port. A design whose clear mask used the wrong polarity, or reached the wrong port, would lose or keep the wrong flags. A design that latched on re-enable would show an event with no edge. The bench also checks edge direction, the cycle in which an event is latched, and the lines beyond the capable ports. In these cases a design with the polarity inverted, an extra synchroniser stage, or events leaking into the upper ports or the summary would be seen.

// File: rtl/pio_edge_pkg.sv
package pio_edge_pkg;

  localparam int ADDR_W = 4;
  localparam int PORT_W = 8;

  localparam logic [ADDR_W-1:0] OFS_SUMMARY = 4'd6;
  localparam logic [ADDR_W-1:0] OFS_PAGE    = 4'd7;
  localparam logic [ADDR_W-1:0] OFS_PAGED0  = 4'd8;

  localparam logic [PORT_W-1:0] CODE_ENABLE   = 8'h80;
  localparam logic [PORT_W-1:0] CODE_POLARITY = 8'h40;
  localparam logic [PORT_W-1:0] CODE_EVENT    = 8'hC0;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_EN   = 2'd1,
    SEL_POL  = 2'd2,
    SEL_EVT  = 2'd3
  } page_sel_e;

  // Map the raw page byte onto the bank that the shared offsets reach.
  function automatic page_sel_e decode_page(input logic [PORT_W-1:0] code);
    case (code)
      CODE_ENABLE:   return SEL_EN;
      CODE_POLARITY: return SEL_POL;
      CODE_EVENT:    return SEL_EVT;
      default:       return SEL_NONE;
    endcase
  endfunction

  // Per-line edge hit: rising where pol=1, falling where pol=0.
  function automatic logic [PORT_W-1:0] edge_hits(input logic [PORT_W-1:0] prev,
                                                  input logic [PORT_W-1:0] cur,
                                                  input logic [PORT_W-1:0] pol);
    return (pol & cur & ~prev) | (~pol & prev & ~cur);
  endfunction

  // Next value of a port's event flags: set on enabled hits, clear wins.
  function automatic logic [PORT_W-1:0] next_events(input logic [PORT_W-1:0] evt,
                                                    input logic [PORT_W-1:0] hit,
                                                    input logic [PORT_W-1:0] en,
                                                    input logic [PORT_W-1:0] clr);
    return (evt | (hit & en)) & ~clr;
  endfunction

endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] prev_o
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign sync_o = sync_q;
  assign prev_o = prev_q;

endmodule

// File: rtl/pio_event_port.sv
module pio_event_port
  import pio_edge_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] cur_i,
  input  logic [PORT_W-1:0] prev_i,
  input  logic [PORT_W-1:0] pol_i,
  input  logic [PORT_W-1:0] en_i,
  input  logic [PORT_W-1:0] clr_i,
  output logic [PORT_W-1:0] hit_o,
  output logic [PORT_W-1:0] evt_o,
  output logic              any_o
);

  logic [PORT_W-1:0] evt_q;

  assign hit_o = edge_hits(prev_i, cur_i, pol_i);

  always_ff @(posedge clk) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= next_events(evt_q, hit_o, en_i, clr_i);
  end

  assign evt_o = evt_q;
  assign any_o = |evt_q;

endmodule

// File: rtl/pio_edge_irq.sv
module pio_edge_irq
  import pio_edge_pkg::*;
#(
  parameter int NUM_PORTS = 6,
  parameter int IRQ_PORTS = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           host_addr,
  input  logic                        host_wr,
  input  logic [PORT_W-1:0]           host_wdata,
  output logic [PORT_W-1:0]           host_rdata,
  input  logic [NUM_PORTS*PORT_W-1:0] line_in,
  output logic [NUM_PORTS*PORT_W-1:0] line_drive,
  output logic                        irq
);

  localparam int LINES     = NUM_PORTS * PORT_W;
  localparam int IRQ_LINES = IRQ_PORTS * PORT_W;

  logic [LINES-1:0]     line_sync;
  logic [LINES-1:0]     line_prev;
  logic [LINES-1:0]     drive_q;
  logic [PORT_W-1:0]    page_q;
  page_sel_e            page_sel;
  logic [IRQ_LINES-1:0] en_q;
  logic [IRQ_LINES-1:0] pol_q;
  logic [IRQ_LINES-1:0] evt_all;
  logic [IRQ_LINES-1:0] hit_all;
  logic [IRQ_LINES-1:0] clr_all;
  logic [IRQ_PORTS-1:0] port_pending;

  // Named write strobes, one per target.
  logic                 wr_page;
  logic [NUM_PORTS-1:0] wr_data_port;
  logic [IRQ_PORTS-1:0] wr_en_port;
  logic [IRQ_PORTS-1:0] wr_pol_port;

  assign page_sel = decode_page(page_q);

  pio_sync #(.W(LINES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_i    (line_in),
    .sync_o (line_sync),
    .prev_o (line_prev)
  );

  always_comb begin
    wr_page = host_wr && (host_addr == OFS_PAGE);
    for (int p = 0; p < NUM_PORTS; p++) begin
      wr_data_port[p] = host_wr && (host_addr == ADDR_W'(p));
    end
    for (int q = 0; q < IRQ_PORTS; q++) begin
      wr_en_port[q]  = host_wr && (host_addr == OFS_PAGED0 + ADDR_W'(q)) && (page_sel == SEL_EN);
      wr_pol_port[q] = host_wr && (host_addr == OFS_PAGED0 + ADDR_W'(q)) && (page_sel == SEL_POL);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q  <= '0;
      drive_q <= '0;
      en_q    <= '0;
      pol_q   <= '0;
    end else begin
      if (wr_page) page_q <= host_wdata;
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (wr_data_port[p]) drive_q[p*PORT_W +: PORT_W] <= host_wdata;
      end
      for (int q = 0; q < IRQ_PORTS; q++) begin
        if (wr_en_port[q])  en_q[q*PORT_W +: PORT_W]  <= host_wdata;
        if (wr_pol_port[q]) pol_q[q*PORT_W +: PORT_W] <= host_wdata;
      end
    end
  end

  // Acknowledge: enable bits written as 0 clear their events.
  always_comb begin
    for (int q = 0; q < IRQ_PORTS; q++) begin
      clr_all[q*PORT_W +: PORT_W] = wr_en_port[q] ? ~host_wdata : '0;
    end
  end

  for (genvar g = 0; g < IRQ_PORTS; g++) begin : g_evt
    pio_event_port u_evt (
      .clk    (clk),
      .rst_n  (rst_n),
      .cur_i  (line_sync[g*PORT_W +: PORT_W]),
      .prev_i (line_prev[g*PORT_W +: PORT_W]),
      .pol_i  (pol_q[g*PORT_W +: PORT_W]),
      .en_i   (en_q[g*PORT_W +: PORT_W]),
      .clr_i  (clr_all[g*PORT_W +: PORT_W]),
      .hit_o  (hit_all[g*PORT_W +: PORT_W]),
      .evt_o  (evt_all[g*PORT_W +: PORT_W]),
      .any_o  (port_pending[g])
    );
  end

  always_comb begin
    host_rdata = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (host_addr == ADDR_W'(p)) host_rdata = line_sync[p*PORT_W +: PORT_W];
    end
    if (host_addr == OFS_SUMMARY) host_rdata[IRQ_PORTS-1:0] = port_pending;
    if (host_addr == OFS_PAGE)    host_rdata = page_q;
    for (int q = 0; q < IRQ_PORTS; q++) begin
      if (host_addr == OFS_PAGED0 + ADDR_W'(q)) begin
        case (page_sel)
          SEL_EN:  host_rdata = en_q[q*PORT_W +: PORT_W];
          SEL_POL: host_rdata = pol_q[q*PORT_W +: PORT_W];
          SEL_EVT: host_rdata = evt_all[q*PORT_W +: PORT_W];
          default: host_rdata = '0;
        endcase
      end
    end
  end

  assign line_drive = drive_q;
  assign irq        = |port_pending;

endmodule

// File: rtl/pio_edge_irq_chk.sv
module pio_edge_irq_chk
  import pio_edge_pkg::*;
#(
  parameter int NUM_PORTS = 6,
  parameter int IRQ_PORTS = 3
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [ADDR_W-1:0]             host_addr,
  input logic                          host_wr,
  input logic [PORT_W-1:0]             host_wdata,
  input logic [PORT_W-1:0]             host_rdata,
  input logic [NUM_PORTS*PORT_W-1:0]   line_drive,
  input logic                          irq,
  input logic [PORT_W-1:0]             page_q,
  input logic [IRQ_PORTS*PORT_W-1:0]   en_q,
  input logic [IRQ_PORTS*PORT_W-1:0]   evt_all,
  input logic [IRQ_PORTS*PORT_W-1:0]   hit_all
);

  AST_EVENT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_all & ~en_q) == '0); // R5

  AST_PAGE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == OFS_PAGE) |=> (page_q == $past(host_wdata))); // R3

  AST_DRIVE_PORT0: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 4'd0) |=> (line_drive[PORT_W-1:0] == $past(host_wdata))); // R2

  AST_SUMMARY_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr == OFS_SUMMARY) |-> (host_rdata[PORT_W-1:3] == '0)); // R6

  AST_IRQ_VS_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr == OFS_SUMMARY) |-> (irq == (host_rdata != '0))); // R8

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr >= 4'd11) |-> (host_rdata == '0)); // R9

  for (genvar g = 0; g < IRQ_PORTS; g++) begin : g_port
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && host_addr == OFS_PAGED0 + ADDR_W'(g) && page_q == CODE_ENABLE)
      |=> ((evt_all[g*PORT_W +: PORT_W] & ~$past(host_wdata)) == '0)); // R7

    AST_HIT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
      (!(host_wr && host_addr == OFS_PAGED0 + ADDR_W'(g) && page_q == CODE_ENABLE))
      |=> ((($past(hit_all[g*PORT_W +: PORT_W]) & $past(en_q[g*PORT_W +: PORT_W]))
            & ~evt_all[g*PORT_W +: PORT_W]) == '0)); // R4
  end

endmodule

bind pio_edge_irq pio_edge_irq_chk #(.NUM_PORTS(NUM_PORTS), .IRQ_PORTS(IRQ_PORTS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_addr  (host_addr),
  .host_wr    (host_wr),
  .host_wdata (host_wdata),
  .host_rdata (host_rdata),
  .line_drive (line_drive),
  .irq        (irq),
  .page_q     (page_q),
  .en_q       (en_q),
  .evt_all    (evt_all),
  .hit_all    (hit_all)
);

// File: tb/test_pio_edge_irq.sv
module test_pio_edge_irq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  host_addr = '0;
  logic        host_wr = 1'b0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic [47:0] line_in = '0;
  logic [47:0] line_drive;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  pio_edge_irq i_pio_edge_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_addr  (host_addr),
    .host_wr    (host_wr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .line_in    (line_in),
    .line_drive (line_drive),
    .irq        (irq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; host_wr = 1'b0; line_in = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    host_addr = a;
    #1;
    d = host_rdata;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    do_reset();
    rd(4'd7, v);  chk("R1 page after reset", v, 8'h00);
    rd(4'd6, v);  chk("R1 summary after reset", v, 8'h00);
    chk("R1 irq after reset", irq, 1'b0);
    chk("R1 drive after reset", line_drive, 48'h0);
    wr(4'd7, 8'h80);
    rd(4'd8, v);  chk("R1 enables after reset", v, 8'h00);
    wr(4'd7, 8'h40);
    rd(4'd10, v); chk("R1 polarity after reset", v, 8'h00);
  endtask

  task automatic t_ports();
    logic [7:0] v;
    do_reset();
    for (int p = 0; p < 6; p++) wr(4'(p), 8'(8'h11 * (p + 1)));
    chk("R2 drive bytes", line_drive, 48'h665544332211);
    line_in = 48'hA5C3_0F81_7E24;
    edges(1);
    rd(4'd1, v); chk("R2 not yet visible after one edge", v, 8'h00);
    edges(1);
    for (int p = 0; p < 6; p++) begin
      rd(4'(p), v);
      chk("R2 line level read", v, line_in[p*8 +: 8]);
    end
  endtask

  task automatic t_page();
    logic [7:0] v;
    do_reset();
    wr(4'd7, 8'h80); rd(4'd7, v); chk("R3 page readback", v, 8'h80);
    wr(4'd8, 8'h5A);
    wr(4'd7, 8'h40); wr(4'd8, 8'h33);
    rd(4'd8, v); chk("R3 polarity bank", v, 8'h33);
    wr(4'd7, 8'h80);
    rd(4'd8, v); chk("R3 enable bank kept apart", v, 8'h5A);
    wr(4'd7, 8'h12);
    rd(4'd8, v); chk("R3 unknown code reads zero", v, 8'h00);
    wr(4'd8, 8'hFF);
    wr(4'd7, 8'h80);
    rd(4'd8, v); chk("R3 unknown code write ignored (enable)", v, 8'h5A);
    wr(4'd7, 8'h40);
    rd(4'd8, v); chk("R3 unknown code write ignored (polarity)", v, 8'h33);
  endtask

  task automatic t_edges();
    logic [7:0] v;
    do_reset();
    wr(4'd7, 8'h40); wr(4'd9, 8'h01);   // line 8 rising, line 9 falling
    wr(4'd7, 8'h80); wr(4'd9, 8'h03);
    wr(4'd7, 8'hC0);
    line_in[8] = 1'b1;
    edges(2);
    rd(4'd9, v); chk("R4 event not before third edge", v, 8'h00);
    edges(1);
    rd(4'd9, v); chk("R4 rising event on third edge", v, 8'h01);
    rd(4'd6, v); chk("R6 summary port1", v, 8'h02);
    chk("R8 irq high", irq, 1'b1);
    line_in[8] = 1'b0;
    edges(4);
    rd(4'd9, v); chk("R5 event held", v, 8'h01);
    line_in[9] = 1'b1;
    edges(4);
    rd(4'd9, v); chk("R4 rise ignored on falling line", v, 8'h01);
    line_in[9] = 1'b0;
    edges(4);
    rd(4'd9, v); chk("R4 falling event", v, 8'h03);
  endtask

  task automatic t_gate();
    logic [7:0] v;
    do_reset();
    wr(4'd7, 8'h40); wr(4'd8, 8'hFF);
    wr(4'd7, 8'h80); wr(4'd8, 8'hFE);   // line 0 disabled
    wr(4'd7, 8'hC0);
    line_in[0] = 1'b1;
    edges(4);
    rd(4'd8, v); chk("R5 disabled line no event", v, 8'h00);
    chk("R8 irq low with no event", irq, 1'b0);
  endtask

  task automatic t_ack();
    logic [7:0] v;
    do_reset();
    wr(4'd7, 8'h40); wr(4'd8, 8'h03); wr(4'd10, 8'h80);
    wr(4'd7, 8'h80); wr(4'd8, 8'h03); wr(4'd10, 8'h80);
    line_in[0] = 1'b1; line_in[1] = 1'b1; line_in[23] = 1'b1;
    edges(4);
    wr(4'd7, 8'hC0);
    rd(4'd8, v); chk("R4 two events port0", v, 8'h03);
    wr(4'd8, 8'h00);
    rd(4'd8, v); chk("R10 event write ignored", v, 8'h03);
    rd(4'd6, v); chk("R6 summary ports 0 and 2", v, 8'h05);
    wr(4'd7, 8'h80); wr(4'd8, 8'h02);
    wr(4'd7, 8'hC0);
    rd(4'd8, v);  chk("R7 clear line 0 only", v, 8'h02);
    rd(4'd10, v); chk("R7 other port untouched", v, 8'h80);
    wr(4'd7, 8'h80); wr(4'd8, 8'h03);
    edges(2);
    wr(4'd7, 8'hC0);
    rd(4'd8, v); chk("R7 re-arm makes no event", v, 8'h02);
    line_in[0] = 1'b0;
    edges(1);
    line_in[0] = 1'b1;
    edges(4);
    rd(4'd8, v); chk("R7 re-armed line latches", v, 8'h03);
    wr(4'd7, 8'h80); wr(4'd8, 8'h00); wr(4'd10, 8'h00);
    rd(4'd6, v); chk("R6 summary clear", v, 8'h00);
    chk("R8 irq low after ack", irq, 1'b0);
  endtask

  task automatic t_upper();
    logic [7:0] v;
    do_reset();
    wr(4'd7, 8'h40); wr(4'd8, 8'hFF); wr(4'd9, 8'hFF); wr(4'd10, 8'hFF);
    wr(4'd7, 8'h80); wr(4'd8, 8'hFF); wr(4'd9, 8'hFF); wr(4'd10, 8'hFF);
    line_in[47:24] = 24'hFFFFFF;
    edges(4);
    line_in[47:24] = 24'h0;
    edges(4);
    rd(4'd6, v); chk("R9 upper ports no summary", v, 8'h00);
    chk("R9 irq low for upper ports", irq, 1'b0);
    for (int a = 11; a < 16; a++) begin
      rd(4'(a), v); chk("R9 unused offset reads zero", v, 8'h00);
    end
  endtask

  initial begin
    #4000000;
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_ports();
    t_page();
    t_edges();
    t_gate();
    t_ack();
    t_upper();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule